// File: doc/BRIEF.md
# Legacy Memory Region Attribute Decoder

This block steers accesses in the low one-megabyte window between 0xA0000 and 0xFFFFF. For every address it names one target: main DRAM with read and write, DRAM read-only, or the expansion bus. The choice comes from a small set of programmable attribute registers and a system-management-mode input. Seven attribute bytes give two-bit codes for the 64 KB boot region and for twelve 16 KB option segments. A separate video-hole control byte opens the 128 KB range below 0xC0000 to DRAM.

The registers are loaded through a byte-wide configuration port with a write strobe and an 8-bit offset. The same offset reads the stored byte back combinationally. Address decoding is purely combinational. A configuration write affects decoding from the next clock cycle.

Top module: `legacy_region_decoder`

## Requirements
- R1: After reset, offsets 0x59 to 0x5F read 0x00 and offset 0x72 reads 0x02. Every access in 0xC0000 to 0xFFFFF and in 0xA0000 to 0xBFFFF then goes to the bus.
- R2: A write strobe with offset 0x59 to 0x5F or 0x72 stores the data byte, and it reads back from the next cycle. Any other offset reads 0x00, and a write to it changes no register.
- R3: Addresses 0xF0000 to 0xFFFFF take their code from bits 5:4 of the byte at offset 0x59. No other bit of that byte has any effect.
- R4: Segment i = (address − 0xC0000) / 0x4000, for i from 0 to 11, takes its code from the byte at offset 0x5A + i/2. Bits 1:0 are used when i is even and bits 5:4 when i is odd. Bits 3:2 and 7:6 are ignored.
- R5: Code 3 gives to_dram=1, dram_ro=0, to_bus=0. Code 1 on a read gives to_dram=1, dram_ro=1. Codes 0 and 2 give to_bus=1, to_dram=0.
- R6: A write to a region whose code is 1 goes to the bus (to_bus=1, to_dram=0, dram_ro=0), so read-only DRAM is never written.
- R7: Addresses 0xA0000 to 0xBFFFF go to DRAM read-write when bit 6 of the byte at 0x72 is set, or when smm_active is high and bit 3 is set. In every other case they go to the bus.
- R8: Addresses below 0xA0000 or at 0x100000 and above go to DRAM read-write, whatever the registers hold.
- R9: In the cycle that carries a configuration write, decoding still uses the old register value. The new value governs from the following cycle.
- R10: Exactly one of to_dram and to_bus is high at all times, and dram_ro is high only together with to_dram.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Byte stored at cfg_addr (0 if unmapped) |
| smm_active | input | 1 | System-management mode in effect |
| acc_addr | input | ADDR_W | Physical address being decoded |
| acc_write | input | 1 | Access is a write |
| to_dram | output | 1 | Access targets main DRAM |
| dram_ro | output | 1 | DRAM target is read-only |
| to_bus | output | 1 | Access is forwarded to the expansion bus |

## Verification
A configuration write and the decoding of an address in the region that write controls can happen in the same cycle. The bench holds a read of 0xC0000 steady, raises the write strobe with a new code for segment 0, and samples the outputs before the clock edge, where it expects the old target. It samples again after the edge and expects the new one. The same check is run in the video hole, with smm_active changing in the cycle that rewrites the control byte. That check expects the old control byte combined with the new mode level.

// File: rtl/legacy_region_decoder.sv
module legacy_region_decoder #(
  parameter int          ADDR_W    = 32,
  parameter logic [7:0]  ATTR_BASE = 8'h59,
  parameter logic [7:0]  SMRAM_OFS = 8'h72,
  parameter logic [7:0]  SMRAM_RST = 8'h02
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic              smm_active,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_write,
  output logic              to_dram,
  output logic              dram_ro,
  output logic              to_bus
);
  localparam int         NBYTES  = 7;
  localparam logic [7:0] NBYTES8 = 8'(NBYTES);
  localparam logic [5:0] SEG0    = 6'h30;

  logic [7:0] attr_q [NBYTES];
  logic [7:0] smram_q;

  wire [7:0] attr_off = cfg_addr - ATTR_BASE;
  wire       attr_hit = attr_off < NBYTES8;

  for (genvar g = 0; g < NBYTES; g++) begin : g_attr
    always_ff @(posedge clk) begin
      if (!rst_n)
        attr_q[g] <= 8'h00;
      else if (cfg_we && attr_hit && attr_off[2:0] == 3'(g))
        attr_q[g] <= cfg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      smram_q <= SMRAM_RST;
    else if (cfg_we && cfg_addr == SMRAM_OFS)
      smram_q <= cfg_wdata;
  end

  assign cfg_rdata = attr_hit ? attr_q[attr_off[2:0]] :
                     (cfg_addr == SMRAM_OFS) ? smram_q : 8'h00;

  wire       above_mb = |acc_addr[ADDR_W-1:20];
  wire [5:0] seg_idx  = acc_addr[19:14] - SEG0;
  wire [7:0] seg_byte = attr_q[seg_idx[3:1] + 3'd1];
  wire [1:0] seg_code = seg_idx[0] ? seg_byte[5:4] : seg_byte[1:0];
  wire       hole_open = smram_q[6] || (smram_q[3] && smm_active);

  logic [1:0] code;
  always_comb begin
    code = 2'd3;
    if (!above_mb) begin
      case (acc_addr[19:16])
        4'hA, 4'hB:       code = hole_open ? 2'd3 : 2'd0;
        4'hC, 4'hD, 4'hE: code = seg_code;
        4'hF:             code = attr_q[0][5:4];
        default:          code = 2'd3;
      endcase
    end
  end

  assign dram_ro = (code == 2'd1) && !acc_write;
  assign to_dram = (code == 2'd3) || dram_ro;
  assign to_bus  = !to_dram;
endmodule

// File: rtl/legacy_region_decoder_chk.sv
module legacy_region_decoder_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [7:0]        cfg_addr,
  input logic [7:0]        cfg_wdata,
  input logic [7:0]        cfg_rdata,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              acc_write,
  input logic              to_dram,
  input logic              dram_ro,
  input logic              to_bus
);
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    to_dram != to_bus); // R10
  AST_RO_WITH_DRAM: assert property (@(posedge clk) disable iff (!rst_n)
    dram_ro |-> to_dram); // R10
  AST_RO_NEVER_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_write && !to_bus) |-> !dram_ro); // R6
  AST_ABOVE_MB_DRAM: assert property (@(posedge clk) disable iff (!rst_n)
    (|acc_addr[ADDR_W-1:20]) |-> (to_dram && !dram_ro)); // R8
  AST_CTRL_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cfg_we && cfg_addr == 8'h72) && cfg_addr == 8'h72) |-> cfg_rdata == $past(cfg_wdata)); // R2
endmodule

bind legacy_region_decoder legacy_region_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .acc_addr(acc_addr),
  .acc_write(acc_write), .to_dram(to_dram), .dram_ro(dram_ro), .to_bus(to_bus)
);

// File: tb/test_legacy_region_decoder.sv
module test_legacy_region_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = 8'h00;
  logic [7:0]  cfg_wdata = 8'h00;
  logic [7:0]  cfg_rdata;
  logic        smm_active = 1'b0;
  logic [31:0] acc_addr = 32'h0;
  logic        acc_write = 1'b0;
  logic        to_dram, dram_ro, to_bus;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  legacy_region_decoder i_legacy_region_decoder (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .smm_active(smm_active),
    .acc_addr(acc_addr), .acc_write(acc_write), .to_dram(to_dram),
    .dram_ro(dram_ro), .to_bus(to_bus)
  );

  localparam logic [2:0] RW = 3'b100, RO = 3'b110, BUS = 3'b001;

  function automatic logic [2:0] expect_of(input logic [1:0] c, input logic wr);
    if (c == 2'd3) return RW;
    if (c == 2'd1 && !wr) return RO;
    return BUS;
  endfunction

  task automatic cmp(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic cfg_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_rd(input string req, input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk);
    cfg_addr = a;
    #2 cmp(req, cfg_rdata, exp);
  endtask

  task automatic probe(input string req, input logic [31:0] a, input logic wr, input logic [2:0] exp);
    @(negedge clk);
    acc_addr = a; acc_write = wr;
    #2 cmp(req, {5'b0, to_dram, dram_ro, to_bus}, {5'b0, exp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [1:0] f [13];
    logic [7:0] b [7];
    logic [31:0] base, size;
    logic [7:0] ctl [5];
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    for (int k = 0; k < 7; k++) cfg_rd("R1", 8'h59 + 8'(k), 8'h00);
    cfg_rd("R1", 8'h72, 8'h02);
    probe("R1", 32'hF0000, 1'b0, BUS);
    probe("R1", 32'hC4000, 1'b0, BUS);
    probe("R1", 32'hA0000, 1'b0, BUS);

    // R2 unmapped offsets
    cfg_wr(8'h58, 8'hFF); cfg_wr(8'h60, 8'hFF); cfg_wr(8'h71, 8'hFF);
    cfg_rd("R2", 8'h58, 8'h00); cfg_rd("R2", 8'h60, 8'h00); cfg_rd("R2", 8'h71, 8'h00);
    cfg_rd("R2", 8'h59, 8'h00); cfg_rd("R2", 8'h72, 8'h02);

    // R3 R4 R5 R6 sweep: region r (0 = top 64KB, 1..12 = segment r-1)
    for (int r = 0; r < 13; r++) begin
      for (int v = 0; v < 4; v++) begin
        for (int j = 0; j < 13; j++) f[j] = (j == r) ? 2'(v) : 2'(3 - v);
        b[0] = {2'b11, f[0], 4'hF};
        for (int k = 1; k < 7; k++) b[k] = {2'b11, f[2*k], 2'b11, f[2*k-1]};
        for (int k = 0; k < 7; k++) cfg_wr(8'h59 + 8'(k), b[k]);
        for (int k = 0; k < 7; k++) cfg_rd("R2", 8'h59 + 8'(k), b[k]);
        if (r == 0) begin base = 32'hF0000; size = 32'h10000; end
        else begin base = 32'hC0000 + 32'(r - 1) * 32'h4000; size = 32'h4000; end
        for (int w = 0; w < 2; w++) begin
          probe(r == 0 ? "R3" : "R4", base, w[0], expect_of(2'(v), w[0]));
          probe("R5", base + size / 2 + 32'h123, w[0], expect_of(2'(v), w[0]));
          probe(v == 1 && w == 1 ? "R6" : "R5", base + size - 1, w[0], expect_of(2'(v), w[0]));
        end
      end
    end

    // R7 video hole
    ctl[0] = 8'h00; ctl[1] = 8'h08; ctl[2] = 8'h40; ctl[3] = 8'h48; ctl[4] = 8'hB7;
    for (int c = 0; c < 5; c++) begin
      cfg_wr(8'h72, ctl[c]);
      for (int s = 0; s < 2; s++) begin
        smm_active = s[0];
        for (int w = 0; w < 2; w++) begin
          probe("R7", 32'hA0000, w[0], (ctl[c][6] || (ctl[c][3] && s == 1)) ? RW : BUS);
          probe("R7", 32'hBFFFF, w[0], (ctl[c][6] || (ctl[c][3] && s == 1)) ? RW : BUS);
        end
      end
    end
    smm_active = 1'b0;

    // R8 outside window
    probe("R8", 32'h00000, 1'b1, RW);
    probe("R8", 32'h9FFFF, 1'b0, RW);
    probe("R8", 32'h100000, 1'b1, RW);
    probe("R8", 32'hFFFFFFFF, 1'b0, RW);
    probe("R8", 32'h100F0000, 1'b0, RW);

    // R9 write coinciding with decode of the same segment
    cfg_wr(8'h5A, 8'h00);
    probe("R9", 32'hC0000, 1'b0, BUS);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 8'h5A; cfg_wdata = 8'h03;
    #2 cmp("R9", {5'b0, to_dram, dram_ro, to_bus}, {5'b0, BUS});
    @(posedge clk); #2
    cmp("R9", {5'b0, to_dram, dram_ro, to_bus}, {5'b0, RW});
    @(negedge clk) cfg_we = 1'b0;

    // R9 video hole: control byte rewritten while smm_active rises
    cfg_wr(8'h72, 8'h00);
    probe("R9", 32'hA8000, 1'b0, BUS);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 8'h72; cfg_wdata = 8'h08; smm_active = 1'b1;
    #2 cmp("R9", {5'b0, to_dram, dram_ro, to_bus}, {5'b0, BUS});
    @(posedge clk); #2
    cmp("R9", {5'b0, to_dram, dram_ro, to_bus}, {5'b0, RW});
    @(negedge clk) cfg_we = 1'b0;

    // R10 exclusivity across a sample of states
    for (int a = 0; a < 16; a++) begin
      @(negedge clk);
      acc_addr = 32'h90000 + 32'(a) * 32'h8000; acc_write = a[0];
      #2 cmp("R10", {6'b0, to_dram ^ to_bus, !dram_ro || to_dram}, 8'h03);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule